// File: doc/BRIEF.md
# Indexed Global Configuration Register Bank

This block holds the chip-wide configuration registers that a host reaches through a pair of byte ports. A write to the index port latches an 8-bit register number. Later reads and writes on the data port then reach whichever register that number selects. Three registers are implemented:

- a control register whose bit 0 asks for a soft reset and clears itself;
- a run-mode access register that holds an enable bit and a two-bit port selector;
- a logical-device register that names the device later commands act on.

Every access depends on a configuration-mode input. While that input is low, the bank ignores writes and returns zero on reads. The block drives out the soft-reset pulse, the run-mode enable, the decoded run-mode port address and the logical-device number. These outputs let neighbouring logic act on the settings without reading the registers back.

Top module: `cfg_regbank`

## Requirements
- R1: After the hardware reset input (`rst_n` low), the index latch is 0x00. Register 0x03 reads 0x03, `run_access_en` is 0, `run_port_addr` is 0xEA, `ldev_num` is 0x00 and `soft_rst_pulse` is 0.
- R2: All 8 bits of the index are decoded. Only 0x02, 0x03 and 0x07 are implemented. Any other index, 0x83 and 0x87 included, discards data writes and reads 0x00.
- R3: When `cfg_mode` is 0, index writes and data writes change nothing. `rdata` is 0x00 whenever `cfg_mode` or `data_rd` is 0.
- R4: Register 0x02 is write-only and reads back 0x00.
- R5: A data write to 0x02 with bit 0 set raises `soft_rst_pulse` for exactly the one cycle after the write edge. A write with bit 0 clear gives no pulse.
- R6: A soft reset returns register 0x03 to 0x03 and register 0x07 to 0x00 on the write edge. The index latch keeps its value.
- R7: Bit 7 of register 0x03 drives `run_access_en`. Bits 6:2 of that register discard writes and read as zero.
- R8: Bits 1:0 of register 0x03 select `run_port_addr`: 2'b11 gives 0xEA, 2'b10 gives 0xE4, 2'b01 gives 0xE2 and 2'b00 gives 0xE0.
- R9: Register 0x07 is a full 8-bit read/write register. Its value appears on `ldev_num` from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| cfg_mode | input | 1 | Configuration mode; high enables all access |
| idx_wr | input | 1 | Write strobe for the index port |
| data_wr | input | 1 | Write strobe for the data port |
| data_rd | input | 1 | Read enable for the data port |
| wdata | input | 8 | Write data for the index and data ports |
| rdata | output | 8 | Read data from the selected register |
| soft_rst_pulse | output | 1 | One-cycle soft-reset request |
| run_access_en | output | 1 | Run-mode access enable |
| run_port_addr | output | 8 | Decoded run-mode access port address |
| ldev_num | output | 8 | Current logical device number |

## Verification
The bench uses the default 8-bit index and data widths. At that size every index value from 0x00 to 0xFF can be written and read back, so the sweep covers all 256 indices. It writes a data pattern that differs for each index. After every write it compares the read-back value and all three outputs with a small arithmetic model. Because of this, an aliased decode, a write that reaches a reserved bit, or a soft reset at the wrong index shows up as a mismatch. Separate passes step the port selector through all four codes, check the pulse timing and the index kept after a soft reset, and repeat writes with configuration mode low.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

    localparam int unsigned REG_W = 8;
    localparam int unsigned SEL_W = 2;

    typedef struct packed {
        logic             run_en;
        logic [SEL_W-1:0] port_sel;
        logic [REG_W-1:0] ldev;
        logic             srst;
    } core_state_t;

    localparam logic [SEL_W-1:0] SEL_DEFAULT = 2'b11;

endpackage

// File: rtl/cfg_idx_latch.sv
module cfg_idx_latch #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] idx
);
    logic [AW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (load) begin
            idx_d = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign idx = idx_q;
endmodule

// File: rtl/cfg_reg_core.sv
module cfg_reg_core
    import cfg_regbank_pkg::*;
#(
    parameter int unsigned AW        = 8,
    parameter logic [7:0]  IDX_CTRL  = 8'h02,
    parameter logic [7:0]  IDX_PORT  = 8'h03,
    parameter logic [7:0]  IDX_LDEV  = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    idx,
    input  logic [REG_W-1:0] wdata,
    output logic             run_en,
    output logic [SEL_W-1:0] port_sel,
    output logic [REG_W-1:0] ldev,
    output logic             srst
);
    localparam core_state_t DEFAULTS = '{
        run_en:   1'b0,
        port_sel: SEL_DEFAULT,
        ldev:     '0,
        srst:     1'b0
    };

    core_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.srst = 1'b0;
        if (wr_en) begin
            if (idx == AW'(IDX_CTRL)) begin
                if (wdata[0]) begin
                    st_d      = DEFAULTS;
                    st_d.srst = 1'b1;
                end
            end else if (idx == AW'(IDX_PORT)) begin
                st_d.run_en   = wdata[REG_W-1];
                st_d.port_sel = wdata[SEL_W-1:0];
            end else if (idx == AW'(IDX_LDEV)) begin
                st_d.ldev = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DEFAULTS;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_en   = st_q.run_en;
    assign port_sel = st_q.port_sel;
    assign ldev     = st_q.ldev;
    assign srst     = st_q.srst;
endmodule

// File: rtl/cfg_port_map.sv
module cfg_port_map
    import cfg_regbank_pkg::*;
#(
    parameter logic [7:0] PORT_S0 = 8'hE0,
    parameter logic [7:0] PORT_S1 = 8'hE2,
    parameter logic [7:0] PORT_S2 = 8'hE4,
    parameter logic [7:0] PORT_S3 = 8'hEA
) (
    input  logic [SEL_W-1:0] sel,
    output logic [REG_W-1:0] addr
);
    always_comb begin
        unique case (sel)
            2'b00:   addr = PORT_S0;
            2'b01:   addr = PORT_S1;
            2'b10:   addr = PORT_S2;
            default: addr = PORT_S3;
        endcase
    end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_regbank_pkg::*;
#(
    parameter int unsigned AW       = 8,
    parameter logic [7:0]  IDX_PORT = 8'h03,
    parameter logic [7:0]  IDX_LDEV = 8'h07
) (
    input  logic             rd_en,
    input  logic [AW-1:0]    idx,
    input  logic             run_en,
    input  logic [SEL_W-1:0] port_sel,
    input  logic [REG_W-1:0] ldev,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (idx == AW'(IDX_PORT)) begin
                rdata[REG_W-1]   = run_en;
                rdata[SEL_W-1:0] = port_sel;
            end else if (idx == AW'(IDX_LDEV)) begin
                rdata = ldev;
            end
        end
    end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_regbank_pkg::*;
#(
    parameter int unsigned AW       = 8,
    parameter logic [7:0]  IDX_CTRL = 8'h02,
    parameter logic [7:0]  IDX_PORT = 8'h03,
    parameter logic [7:0]  IDX_LDEV = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             idx_wr,
    input  logic             data_wr,
    input  logic             data_rd,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             soft_rst_pulse,
    output logic             run_access_en,
    output logic [REG_W-1:0] run_port_addr,
    output logic [REG_W-1:0] ldev_num
);
    logic [AW-1:0]    idx_q;
    logic [SEL_W-1:0] port_sel;

    cfg_idx_latch #(.AW(AW)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_mode && idx_wr),
        .din   (AW'(wdata)),
        .idx   (idx_q)
    );

    cfg_reg_core #(
        .AW(AW), .IDX_CTRL(IDX_CTRL), .IDX_PORT(IDX_PORT), .IDX_LDEV(IDX_LDEV)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_mode && data_wr),
        .idx      (idx_q),
        .wdata    (wdata),
        .run_en   (run_access_en),
        .port_sel (port_sel),
        .ldev     (ldev_num),
        .srst     (soft_rst_pulse)
    );

    cfg_port_map u_map (
        .sel  (port_sel),
        .addr (run_port_addr)
    );

    cfg_read_mux #(
        .AW(AW), .IDX_PORT(IDX_PORT), .IDX_LDEV(IDX_LDEV)
    ) u_rd (
        .rd_en    (cfg_mode && data_rd),
        .idx      (idx_q),
        .run_en   (run_access_en),
        .port_sel (port_sel),
        .ldev     (ldev_num),
        .rdata    (rdata)
    );
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
    parameter int unsigned AW       = 8,
    parameter logic [7:0]  IDX_CTRL = 8'h02
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_mode,
    input logic          data_wr,
    input logic          data_rd,
    input logic [7:0]    wdata,
    input logic [AW-1:0] idx,
    input logic [7:0]    rdata,
    input logic          soft_rst_pulse,
    input logic          run_access_en,
    input logic [7:0]    run_port_addr,
    input logic [7:0]    ldev_num
);
    // R3
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode || !data_rd) |-> rdata == 8'h00);

    // R3
    no_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> ($stable(ldev_num) && $stable(run_access_en) && $stable(run_port_addr)));

    // R4
    ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx == AW'(IDX_CTRL) |-> rdata == 8'h00);

    // R5
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |-> $past(cfg_mode && data_wr && idx == AW'(IDX_CTRL) && wdata[0]));

    // R6
    pulse_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |-> (ldev_num == 8'h00 && !run_access_en && run_port_addr == 8'hEA));

    // R6
    pulse_keeps_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |-> $stable(idx));

    // R8
    port_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_port_addr == 8'hE0 || run_port_addr == 8'hE2 ||
        run_port_addr == 8'hE4 || run_port_addr == 8'hEA);
endmodule

bind cfg_regbank cfg_regbank_chk #(.AW(AW), .IDX_CTRL(IDX_CTRL)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_mode       (cfg_mode),
    .data_wr        (data_wr),
    .data_rd        (data_rd),
    .wdata          (wdata),
    .idx            (idx_q),
    .rdata          (rdata),
    .soft_rst_pulse (soft_rst_pulse),
    .run_access_en  (run_access_en),
    .run_port_addr  (run_port_addr),
    .ldev_num       (ldev_num)
);

// File: tb/cfg_regbank_test.sv
module cfg_regbank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b0;
    logic       idx_wr = 1'b0;
    logic       data_wr = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       soft_rst_pulse;
    logic       run_access_en;
    logic [7:0] run_port_addr;
    logic [7:0] ldev_num;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] m_port = 8'h03;
    logic [7:0] m_ldev = 8'h00;

    always #4 clk = ~clk;

    cfg_regbank uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .idx_wr(idx_wr),
        .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata), .rdata(rdata),
        .soft_rst_pulse(soft_rst_pulse), .run_access_en(run_access_en),
        .run_port_addr(run_port_addr), .ldev_num(ldev_num)
    );

    function automatic logic [7:0] port_of(input logic [1:0] s);
        case (s)
            2'b00:   return 8'hE0;
            2'b01:   return 8'hE2;
            2'b10:   return 8'hE4;
            default: return 8'hEA;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_idx(input logic [7:0] v);
        @(negedge clk); idx_wr = 1'b1; wdata = v;
        @(negedge clk); idx_wr = 1'b0;
    endtask

    task automatic put_data(input logic [7:0] v, output logic pulse);
        @(negedge clk); data_wr = 1'b1; wdata = v;
        @(negedge clk); data_wr = 1'b0; pulse = soft_rst_pulse;
    endtask

    task automatic get_data(output logic [7:0] v);
        @(negedge clk); data_rd = 1'b1;
        #1 v = rdata;
        data_rd = 1'b0;
    endtask

    task automatic check_outputs(input string req);
        check({req, " run_en"}, {7'd0, run_access_en}, {7'd0, m_port[7]});
        check({req, " port"}, run_port_addr, port_of(m_port[1:0]));
        check({req, " ldev"}, ldev_num, m_ldev);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] rv;
        logic       p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pulse", {7'd0, soft_rst_pulse}, 8'h00);
        check_outputs("R1");
        cfg_mode = 1'b1;
        get_data(rv);
        check("R1 idx0 read", rv, 8'h00);
        put_idx(8'h03);
        get_data(rv);
        check("R1 reg03 default", rv, 8'h03);

        // R2 R4 R5 R7 R9 sweep over every index
        for (int i = 0; i < 256; i++) begin
            logic [7:0] d;
            logic       exp_p;
            d = 8'(i) ^ 8'hA5;
            exp_p = 1'b0;
            if (i == 3) m_port = d & 8'h83;
            else if (i == 7) m_ldev = d;
            else if (i == 2 && d[0]) begin m_port = 8'h03; m_ldev = 8'h00; exp_p = 1'b1; end
            put_idx(8'(i));
            put_data(d, p);
            check("R5 pulse sweep", {7'd0, p}, {7'd0, exp_p});
            get_data(rv);
            check("R2 R4 R7 R9 read", rv, (i == 3) ? m_port : (i == 7) ? m_ldev : 8'h00);
            check_outputs("R2 R7 R9");
        end

        // R8 all four selector codes, with and without enable
        put_idx(8'h03);
        for (int s = 0; s < 8; s++) begin
            logic [7:0] d;
            d = {s[2], 5'b11111, s[1:0]};
            put_data(d, p);
            m_port = d & 8'h83;
            check("R8 port", run_port_addr, port_of(2'(s)));
            check("R7 enable", {7'd0, run_access_en}, {7'd0, s[2]});
            get_data(rv);
            check("R7 reserved bits", rv, m_port);
        end

        // R9 ldev patterns
        put_idx(8'h07);
        for (int k = 0; k < 8; k++) begin
            put_data(8'(1 << k), p);
            m_ldev = 8'(1 << k);
            check("R9 ldev", ldev_num, m_ldev);
        end

        // R5 bit0 clear gives no pulse and changes nothing
        put_idx(8'h02);
        put_data(8'hFE, p);
        check("R5 no pulse", {7'd0, p}, 8'h00);
        check_outputs("R5");

        // R5 R6 pulse length, defaults, index kept
        put_data(8'h01, p);
        check("R5 pulse", {7'd0, p}, 8'h01);
        m_port = 8'h03; m_ldev = 8'h00;
        check_outputs("R6");
        @(negedge clk);
        check("R5 pulse one cycle", {7'd0, soft_rst_pulse}, 8'h00);
        put_data(8'h01, p);
        check("R6 index kept", {7'd0, p}, 8'h01);
        @(negedge clk);

        // R3 configuration mode off
        put_idx(8'h07);
        put_data(8'h5C, p);
        m_ldev = 8'h5C;
        cfg_mode = 1'b0;
        get_data(rv);
        check("R3 read gated", rv, 8'h00);
        put_data(8'h11, p);
        check("R3 write ignored", ldev_num, 8'h5C);
        put_idx(8'h02);
        put_data(8'h01, p);
        check("R3 no pulse", {7'd0, p}, 8'h00);
        cfg_mode = 1'b1;
        get_data(rv);
        check("R3 index write ignored", rv, 8'h5C);
        check_outputs("R3");

        finish_run();
    end
endmodule